// File: doc/BRIEF.md
# Edge-Triggered Tracking Shift Register

This block keeps a 128-position occupancy map of the kind used to follow items along a conveyor. The map is held as four 32-bit words. Each time the trigger input goes from low to high, every position moves one place toward position 0, and a zero enters at the far end. If the data input is high on that same advance, one position chosen at run time by a 7-bit index is marked with a 1.

Position 0 is driven out continuously as a serial output. All four words are also visible as a read-only output, so the whole map can be observed after each advance. The trigger is sampled every clock, and a steady high level never causes more than one advance.

Top module: `trk_shift_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, all 128 positions and the serial output read 0 until the first advance.
- R2: An advance happens only in a clock where the trigger is 1 and was 0 in the previous clock. A trigger that stays high gives exactly one advance.
- R3: On an advance, position p takes the old value of position p+1. Bit 0 of word n moves into bit 31 of word n-1.
- R4: On an advance, position 127 (word 3, bit 31) becomes 0, unless that same advance sets it.
- R5: On an advance with the data input at 1 and an index k from 1 to 127, position k reads 1 afterwards. Word k/32 (index bits 6:5) and bit k%32 (index bits 4:0) are addressed, so index 100 is word 3, bit 4. The set applies to the value after the shift, so the marked bit is not moved on that edge.
- R6: An index of 0 sets nothing, and the register still shifts normally.
- R7: With the data input at 0, an advance is a plain shift and no position is set.
- R8: The serial output always equals position 0 (word 0, bit 0).
- R9: In a clock with no advance, all 128 positions keep their value.
- R10: Output word n holds positions 32n to 32n+31, with bit j of word n equal to position 32n+j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_i | input | 1 | Trigger; a 0-to-1 transition advances the register |
| din_i | input | 1 | When 1 on an advance, marks the indexed position |
| idx_i | input | 7 | Position to mark, 1 to 127; 0 marks nothing |
| serial_o | output | 1 | Position 0 |
| words_o | output | 4 x 32 | Read-only view of the four words, word 0 in the low bits |

## Verification
The bench builds the block with the default 32-bit words and four words, so the 7-bit index covers the whole map. This brings the boundary positions 31/32, 63/64 and 95/96, the top position 127 and the suppressed index 0 within reach. Directed edges place marks on those positions and follow them across word boundaries and out through the serial output. A long run of random trigger, data and index values follows, with held trigger levels mixed in, and is compared against a flat 128-bit model on every clock.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int DEF_WORD_W    = 32;
  localparam int DEF_NUM_WORDS = 4;

  function automatic int idx_width(input int word_w, input int num_words);
    return $clog2(word_w * num_words);
  endfunction
endpackage

// File: rtl/trk_reset_sync.sv
module trk_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/trk_edge_detect.sv
module trk_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic advance_o
);
  logic trig_q;

  assign advance_o = trig_i & ~trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  // One advance per rising edge.
  assert_single_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |=> !advance_o);
endmodule

// File: rtl/trk_word_slice.sv
module trk_word_slice #(
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 7,
  parameter int SLICE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance_i,
  input  logic              carry_i,
  input  logic              set_en_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int SEL_W = IDX_W - BIT_W;

  logic [WORD_W-1:0] word_q, word_d, shifted, mask;
  logic              hit;

  assign hit    = set_en_i && (set_idx_i[IDX_W-1:BIT_W] == SEL_W'(SLICE_ID));
  assign word_o = word_q;

  always_comb begin
    shifted = {carry_i, word_q[WORD_W-1:1]};
    mask    = '0;
    if (hit) mask[set_idx_i[BIT_W-1:0]] = 1'b1;
    word_d  = word_q;
    if (advance_i) word_d = shifted | mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(word_o));

  assert_carry_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !(hit && set_idx_i[BIT_W-1:0] == BIT_W'(WORD_W-1)))
      |=> word_o[WORD_W-1] == $past(carry_i));
endmodule

// File: rtl/trk_shift_tracker.sv
module trk_shift_tracker
  import trk_pkg::*;
#(
  parameter int WORD_W    = DEF_WORD_W,
  parameter int NUM_WORDS = DEF_NUM_WORDS,
  localparam int TOTAL    = WORD_W * NUM_WORDS,
  localparam int IDX_W    = idx_width(WORD_W, NUM_WORDS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             trig_i,
  input  logic                             din_i,
  input  logic [IDX_W-1:0]                 idx_i,
  output logic                             serial_o,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] words_o
);
  logic             rst_n_sync;
  logic             advance;
  logic             set_en;
  logic [TOTAL-1:0] flat;

  trk_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  trk_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .trig_i    (trig_i),
    .advance_o (advance)
  );

  assign set_en = din_i && (idx_i != '0);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic carry;
    if (w == NUM_WORDS - 1) begin : g_top
      assign carry = 1'b0;
    end else begin : g_mid
      assign carry = words_o[w+1][0];
    end

    trk_word_slice #(
      .WORD_W   (WORD_W),
      .IDX_W    (IDX_W),
      .SLICE_ID (w)
    ) u_slice (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .advance_i (advance),
      .carry_i   (carry),
      .set_en_i  (set_en),
      .set_idx_i (idx_i),
      .word_o    (words_o[w])
    );
  end

  assign flat     = words_o;
  assign serial_o = words_o[0][0];

  assert_plain_shift_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (advance && !set_en) |=> flat == ($past(flat) >> 1));

  assert_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (advance && !(set_en && idx_i == IDX_W'(TOTAL-1))) |=> !flat[TOTAL-1]);

  assert_mark_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (advance && set_en) |=> flat[$past(idx_i)]);

  assert_index_zero_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (advance && din_i && idx_i == '0) |=> flat == ($past(flat) >> 1));

  assert_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (trig_i && $past(trig_i)) |=> $stable(flat));

  assert_serial_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (advance && !(set_en && idx_i == IDX_W'(1))) |=> serial_o == $past(flat[1]));
endmodule

// File: tb/trk_shift_tracker_bench.sv
module trk_shift_tracker_bench;
  localparam int TOTAL = 128;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 trig, din;
  logic [6:0]           idx;
  logic                 serial;
  logic [3:0][31:0]     words;
  logic [TOTAL-1:0]     model;
  logic                 prev_trig;
  int                   n_checks = 0;
  int                   n_fail   = 0;
  bit                   compare_on = 1'b0;
  bit                   done = 1'b0;

  always #10 clk = ~clk;

  trk_shift_tracker u_trk_shift_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig),
    .din_i    (din),
    .idx_i    (idx),
    .serial_o (serial),
    .words_o  (words)
  );

  function automatic logic [TOTAL-1:0] flat_view();
    logic [TOTAL-1:0] f;
    for (int n = 0; n < 4; n++)
      for (int j = 0; j < 32; j++) f[32*n+j] = words[n][j];
    return f;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: a flat vector updated on detected edges.
  always @(posedge clk) begin
    if (!rst_n) begin
      model     <= '0;
      prev_trig <= 1'b0;
    end else begin
      prev_trig <= trig;
      if (trig && !prev_trig) begin
        logic [TOTAL-1:0] nxt;
        nxt = model >> 1;
        if (din && idx != 0) nxt[idx] = 1'b1;
        model <= nxt;
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      chk(flat_view() == model, "R3 model compare", flat_view(), model);
      chk(serial == model[0], "R8 serial", {127'b0, serial}, {127'b0, model[0]});
    end
  end

  task automatic pulse(input logic d, input logic [6:0] i);
    @(negedge clk); trig = 1'b1; din = d; idx = i;
    @(negedge clk); trig = 1'b0; din = 1'b0; idx = '0;
  endtask

  initial begin
    rst_n = 1'b0; trig = 1'b0; din = 1'b0; idx = '0;
    repeat (3) @(negedge clk);
    chk(flat_view() == '0 && serial == 1'b0, "R1 reset", flat_view(), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(flat_view() == '0, "R1 after release", flat_view(), '0);
    compare_on = 1'b1;

    pulse(1'b1, 7'd100);
    chk(words[3][4] == 1'b1 && flat_view() == (128'b1 << 100), "R5 index 100", flat_view(), 128'b1 << 100);

    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    chk(flat_view() == (128'b1 << 99), "R2 first high", flat_view(), 128'b1 << 99);
    repeat (4) @(negedge clk);
    chk(flat_view() == (128'b1 << 99), "R2 steady high", flat_view(), 128'b1 << 99);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    chk(flat_view() == (128'b1 << 99), "R9 idle hold", flat_view(), 128'b1 << 99);

    pulse(1'b1, 7'd0);
    chk(flat_view() == (128'b1 << 98), "R6 index zero", flat_view(), 128'b1 << 98);
    pulse(1'b0, 7'd5);
    chk(flat_view() == (128'b1 << 97), "R7 data low", flat_view(), 128'b1 << 97);
    pulse(1'b1, 7'd127);
    chk(words[3][31] == 1'b1 && flat_view() == ((128'b1 << 96) | (128'b1 << 127)),
        "R5 index 127", flat_view(), (128'b1 << 96) | (128'b1 << 127));
    pulse(1'b1, 7'd32);
    chk(words[1][0] == 1'b1 && words[2][31] == 1'b1, "R10 word layout", flat_view(),
        (128'b1 << 95) | (128'b1 << 126) | (128'b1 << 32));
    pulse(1'b0, 7'd0);
    chk(words[0][31] == 1'b1 && words[1][0] == 1'b0, "R3 word carry", flat_view(),
        (128'b1 << 94) | (128'b1 << 125) | (128'b1 << 31));
    chk(words[3][31] == 1'b0, "R4 zero at top", flat_view(),
        (128'b1 << 94) | (128'b1 << 125) | (128'b1 << 31));
    pulse(1'b1, 7'd1);
    pulse(1'b0, 7'd0);
    chk(serial == 1'b1, "R8 serial out", {127'b0, serial}, 128'b1);

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      trig = 1'($urandom_range(0, 2) == 0) ^ trig;
      din  = 1'($urandom_range(0, 1));
      idx  = 7'($urandom_range(0, 127));
    end
    @(negedge clk); trig = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    compare_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule